// File: doc/BRIEF.md
# DDR SDRAM Bank Activation Timing Guard

This block sits between a memory controller's command source and the command bus of a four-bank DDR SDRAM. Each cycle it judges one requested command (activate, read, write, precharge or no-operation) against the open or closed state of the addressed bank and three activation spacing rules. A legal command is granted and placed on the chip-select, row-strobe, column-strobe and write-enable lines one cycle later. A command that is legal but early is held back with a stall indication. An access to a closed bank, or an activate to an already open bank, is refused with an error indication and never reaches the bus.

The three spacing limits are given as picosecond parameters together with the clock period. They are turned into whole cycle counts at elaboration time by rounding the quotient up. Each bank keeps its own activate-to-access and activate-to-activate timers. One shared timer spaces activates across banks. The block also reports which banks hold an open row and which row each one holds.

Top module: `sdram_act_guard`

## Requirements
- R1: Each limit in cycles is the ceiling of its picosecond value divided by the clock period. With the defaults (7.5 ns clock; 20 ns, 65 ns and 15 ns limits) this gives 3 cycles for activate-to-access, 9 for same-bank activate spacing and 2 for cross-bank activate spacing.
- R2: A read or write (req_cmd 2 or 3) to a bank with no open row raises err in that cycle, is not granted, and the bus shows no-operation in the following cycle.
- R3: A read or write to an open bank is granted only when at least the activate-to-access count of cycles has passed since that bank's activate was granted. Until then stall is high.
- R4: An activate (req_cmd 1) to a bank that is already open raises err, is not granted, and leaves that bank's open flag and stored row unchanged.
- R5: Two activates granted to the same bank are at least the same-bank count of cycles apart, even when the bank was precharged in between. An early activate is stalled.
- R6: Two activates granted to any banks are at least the cross-bank count of cycles apart. An early activate is stalled.
- R7: A precharge (req_cmd 4) is granted at once and closes the addressed bank. This holds even when the bank is already closed.
- R8: In the cycle after a grant the bus carries the command as {cs_n,ras_n,cas_n,we_n}: activate 0011, read 0101, write 0100, precharge 0010, no-operation 0111. bus_ba and bus_addr carry the request's bank and address. In every other cycle the bus carries 0111 with zero bank and address. cke is always 1. Request codes 0 and 5 to 7 are granted as no-operation.
- R9: While req_valid is high, exactly one of grant, stall and err is high. While it is low, none is.
- R10: A granted activate sets the bank's bit in open_mask at the next edge. It also stores the request address in that bank's 13-bit slice of open_rows, where bank i sits at bits 13*i+12 down to 13*i.
- R11: After reset all banks are closed, the bus carries no-operation, and no spacing timer blocks the first activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 3 | Requested command: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge |
| req_ba | input | 2 | Requested bank |
| req_addr | input | 13 | Row for an activate, column for an access |
| grant | output | 1 | Request accepted this cycle |
| stall | output | 1 | Request legal but early; hold it |
| err | output | 1 | Request illegal for the bank state; dropped |
| cke | output | 1 | Clock enable, tied high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bus_ba | output | 2 | Bank address on the bus |
| bus_addr | output | 13 | Address on the bus |
| open_mask | output | 4 | One bit per bank with an open row |
| open_rows | output | 52 | Stored row of each bank, 13 bits per bank |

## Verification
On every cycle the assertions check that each granted access finds its bank open and old enough. They check that each granted activate finds its bank closed and respects both activate spacings, measured by counters kept in the checker itself. They also check that exactly one outcome is signalled per request, that the bus idles after any cycle without a grant, and that activates and precharges update the open mask. Only the bench scenarios show that stall lasts exactly as long as the rounded-up limits demand. They also show that refused commands leave the stored rows untouched and that each command reaches the bus with the right encoding, bank and address.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  localparam logic [3:0] BUS_NOP = 4'b0111;

  // ceiling of t_ps / tck_ps
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned tck_ps);
    return (t_ps + tck_ps - 1) / tck_ps;
  endfunction

  // value loaded into a down-counter so it reaches zero n edges later
  function automatic int unsigned load_of(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] bus_code(input logic [2:0] c);
    case (c)
      CMD_ACT: return 4'b0011;
      CMD_RD:  return 4'b0101;
      CMD_WR:  return 4'b0100;
      CMD_PRE: return 4'b0010;
      default: return BUS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned RCD_LD = 2,
  parameter int unsigned RC_LD  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_done_o,
  output logic             rc_done_o
);

  logic [CNT_W-1:0] rcd_cnt;
  logic [CNT_W-1:0] rc_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else if (act_i) begin
      open_o <= 1'b1;
      row_o  <= row_i;
    end else if (pre_i) begin
      open_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcd_cnt <= '0;
      rc_cnt  <= '0;
    end else if (act_i) begin
      rcd_cnt <= CNT_W'(RCD_LD);
      rc_cnt  <= CNT_W'(RC_LD);
    end else begin
      if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
      if (rc_cnt != '0)  rc_cnt  <= rc_cnt - 1'b1;
    end
  end

  assign rcd_done_o = (rcd_cnt == '0);
  assign rc_done_o  = (rc_cnt == '0);

endmodule

// File: rtl/rrd_timer.sv
module rrd_timer #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LD    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load_i)       cnt <= CNT_W'(LD);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);

endmodule

// File: rtl/cmd_bus_reg.sv
module cmd_bus_reg
  import sdram_guard_pkg::*;
#(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [2:0]       cmd_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [ROW_W-1:0] addr_i,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] addr_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= BUS_NOP;
      ba_o   <= '0;
      addr_o <= '0;
    end else if (issue_i) begin
      {cs_n, ras_n, cas_n, we_n} <= bus_code(cmd_i);
      ba_o   <= ba_i;
      addr_o <= addr_i;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= BUS_NOP;
      ba_o   <= '0;
      addr_o <= '0;
    end
  end

endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
  import sdram_guard_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned T_CK_PS   = 7500,
  parameter int unsigned T_RCD_PS  = 20000,
  parameter int unsigned T_RC_PS   = 65000,
  parameter int unsigned T_RRD_PS  = 15000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [2:0]                req_cmd,
  input  logic [BA_W-1:0]           req_ba,
  input  logic [ROW_W-1:0]          req_addr,
  output logic                      grant,
  output logic                      stall,
  output logic                      err,
  output logic                      cke,
  output logic                      cs_n,
  output logic                      ras_n,
  output logic                      cas_n,
  output logic                      we_n,
  output logic [BA_W-1:0]           bus_ba,
  output logic [ROW_W-1:0]          bus_addr,
  output logic [(1<<BA_W)-1:0]      open_mask,
  output logic [(1<<BA_W)*ROW_W-1:0] open_rows
);

  localparam int unsigned NB      = 1 << BA_W;
  localparam int unsigned RCD_CYC = ps_to_cycles(T_RCD_PS, T_CK_PS);
  localparam int unsigned RC_CYC  = ps_to_cycles(T_RC_PS,  T_CK_PS);
  localparam int unsigned RRD_CYC = ps_to_cycles(T_RRD_PS, T_CK_PS);
  localparam int unsigned CNT_W   = $clog2(max3(RCD_CYC, RC_CYC, RRD_CYC) + 1) + 1;

  logic [NB-1:0] bank_open;
  logic [NB-1:0] rcd_done;
  logic [NB-1:0] rc_done;
  logic          rrd_done;

  // named decision events
  logic want_act, want_acc;
  logic act_issue, pre_issue, acc_issue;
  logic tgt_open, tgt_rcd_ok, tgt_rc_ok;

  assign want_act   = req_valid && (req_cmd == CMD_ACT);
  assign want_acc   = req_valid && ((req_cmd == CMD_RD) || (req_cmd == CMD_WR));
  assign tgt_open   = bank_open[req_ba];
  assign tgt_rcd_ok = rcd_done[req_ba];
  assign tgt_rc_ok  = rc_done[req_ba];

  always_comb begin
    grant = 1'b0;
    stall = 1'b0;
    err   = 1'b0;
    if (want_act) begin
      if (tgt_open)                      err   = 1'b1;
      else if (tgt_rc_ok && rrd_done)    grant = 1'b1;
      else                               stall = 1'b1;
    end else if (want_acc) begin
      if (!tgt_open)                     err   = 1'b1;
      else if (tgt_rcd_ok)               grant = 1'b1;
      else                               stall = 1'b1;
    end else if (req_valid) begin
      grant = 1'b1;
    end
  end

  assign act_issue = grant && (req_cmd == CMD_ACT);
  assign pre_issue = grant && (req_cmd == CMD_PRE);
  assign acc_issue = grant && want_acc;
  assign cke       = 1'b1;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    assign sel = (req_ba == BA_W'(b));
    bank_tracker #(
      .ROW_W (ROW_W),
      .CNT_W (CNT_W),
      .RCD_LD(load_of(RCD_CYC)),
      .RC_LD (load_of(RC_CYC))
    ) trk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (act_issue && sel),
      .pre_i     (pre_issue && sel),
      .row_i     (req_addr),
      .open_o    (bank_open[b]),
      .row_o     (open_rows[b*ROW_W +: ROW_W]),
      .rcd_done_o(rcd_done[b]),
      .rc_done_o (rc_done[b])
    );
  end

  rrd_timer #(
    .CNT_W(CNT_W),
    .LD   (load_of(RRD_CYC))
  ) rrd_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(act_issue),
    .done_o(rrd_done)
  );

  cmd_bus_reg #(
    .BA_W (BA_W),
    .ROW_W(ROW_W)
  ) bus_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue_i(grant),
    .cmd_i  (req_cmd),
    .ba_i   (req_ba),
    .addr_i (req_addr),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .ba_o   (bus_ba),
    .addr_o (bus_addr)
  );

  assign open_mask = bank_open;

endmodule

// File: rtl/sdram_act_guard_chk.sv
module sdram_act_guard_chk #(
  parameter int unsigned BA_W    = 2,
  parameter int unsigned RCD_CYC = 3,
  parameter int unsigned RC_CYC  = 9,
  parameter int unsigned RRD_CYC = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [2:0]           req_cmd,
  input logic [BA_W-1:0]      req_ba,
  input logic                 grant,
  input logic                 stall,
  input logic                 err,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [(1<<BA_W)-1:0] open_mask
);

  localparam int unsigned NB = 1 << BA_W;

  logic [7:0] since_act [NB];
  logic [7:0] since_any;
  logic       g_act, g_acc, g_pre;

  assign g_act = req_valid && grant && (req_cmd == 3'd1);
  assign g_acc = req_valid && grant && ((req_cmd == 3'd2) || (req_cmd == 3'd3));
  assign g_pre = req_valid && grant && (req_cmd == 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) since_act[i] <= 8'hFF;
      since_any <= 8'hFF;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (g_act && (req_ba == BA_W'(i)))  since_act[i] <= 8'd1;
        else if (since_act[i] != 8'hFF)     since_act[i] <= since_act[i] + 8'd1;
      end
      if (g_act)                    since_any <= 8'd1;
      else if (since_any != 8'hFF)  since_any <= since_any + 8'd1;
    end
  end

  p_access_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    g_acc |-> open_mask[req_ba]);

  p_access_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    g_acc |-> (32'(since_act[req_ba]) >= RCD_CYC));

  p_act_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    g_act |-> !open_mask[req_ba]);

  p_same_bank_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    g_act |-> (32'(since_act[req_ba]) >= RC_CYC));

  p_cross_bank_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    g_act |-> (32'(since_any) >= RRD_CYC));

  p_pre_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    g_pre |=> !open_mask[$past(req_ba)]);

  p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && grant) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones({grant, stall, err}) == 1));

  p_no_outcome_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ({grant, stall, err} == 3'b000));

  p_act_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
    g_act |=> open_mask[$past(req_ba)]);

endmodule

bind sdram_act_guard sdram_act_guard_chk #(
  .BA_W   (BA_W),
  .RCD_CYC(RCD_CYC),
  .RC_CYC (RC_CYC),
  .RRD_CYC(RRD_CYC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_cmd  (req_cmd),
  .req_ba   (req_ba),
  .grant    (grant),
  .stall    (stall),
  .err      (err),
  .cs_n     (cs_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .open_mask(open_mask)
);

// File: tb/sdram_act_guard_tb_top.sv
module sdram_act_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TCK = 7500, TRCD = 20000, TRC = 65000, TRRD = 15000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_cmd = 3'd0;
  logic [1:0]  req_ba = 2'd0;
  logic [12:0] req_addr = 13'd0;
  logic        grant, stall, err, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  bus_ba;
  logic [12:0] bus_addr;
  logic [3:0]  open_mask;
  logic [51:0] open_rows;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_act_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_ba(req_ba), .req_addr(req_addr), .grant(grant), .stall(stall),
    .err(err), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bus_ba(bus_ba), .bus_addr(bus_addr),
    .open_mask(open_mask), .open_rows(open_rows)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // reference model state
  int m_open [4];
  int m_row  [4];
  int m_last [4];
  int m_last_any;
  int cyc;
  logic [3:0]  e_bus  = 4'b0111;
  logic [1:0]  e_ba   = 2'd0;
  logic [12:0] e_addr = 13'd0;
  int c_rcd, c_rc, c_rrd;

  // smallest whole cycle count that covers t_ps
  function automatic int cover_cycles(input int t_ps);
    int n = 0;
    while (n * TCK < t_ps) n++;
    return n;
  endfunction

  function automatic logic [3:0] enc(input logic [2:0] c);
    if (c == 3'd1) return 4'b0011;
    if (c == 3'd2) return 4'b0101;
    if (c == 3'd3) return 4'b0100;
    if (c == 3'd4) return 4'b0010;
    return 4'b0111;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic check_state();
    bit ok = 1;
    chk({cs_n, ras_n, cas_n, we_n, bus_ba, bus_addr} == {e_bus, e_ba, e_addr}, "R8",
        "bus", {45'd0, cs_n, ras_n, cas_n, we_n, bus_ba, bus_addr}, {45'd0, e_bus, e_ba, e_addr});
    chk(cke == 1'b1, "R8", "cke", {63'd0, cke}, 64'd1);
    for (int b = 0; b < 4; b++) begin
      if (open_mask[b] != (m_open[b] != 0)) ok = 0;
      if (m_open[b] != 0 && open_rows[b*13 +: 13] != 13'(m_row[b])) ok = 0;
    end
    chk(ok, "R10", "open state", {12'd0, open_mask, open_rows}, {60'd0,
        (m_open[3] != 0), (m_open[2] != 0), (m_open[1] != 0), (m_open[0] != 0)});
  endtask

  task automatic step(input logic v, input logic [2:0] c, input logic [1:0] b,
                      input logic [12:0] a, output bit g, output bit s, output bit e);
    string tag;
    @(negedge clk);
    check_state();
    req_valid = v; req_cmd = c; req_ba = b; req_addr = a;
    #1;
    g = 0; s = 0; e = 0; tag = "R9";
    if (v) begin
      if (c == 3'd1) begin
        tag = "R4 R5 R6";
        if (m_open[b] != 0) e = 1;
        else if (cyc - m_last[b] >= c_rc && cyc - m_last_any >= c_rrd) g = 1;
        else s = 1;
      end else if (c == 3'd2 || c == 3'd3) begin
        tag = "R2 R3";
        if (m_open[b] == 0) e = 1;
        else if (cyc - m_last[b] >= c_rcd) g = 1;
        else s = 1;
      end else begin
        tag = (c == 3'd4) ? "R7" : "R9";
        g = 1;
      end
    end
    chk({grant, stall, err} == {g, s, e}, tag, "grant/stall/err",
        {61'd0, grant, stall, err}, {61'd0, g, s, e});
    if (g) begin
      if (c == 3'd1) begin
        m_open[b] = 1; m_row[b] = a; m_last[b] = cyc; m_last_any = cyc;
      end else if (c == 3'd4) begin
        m_open[b] = 0;
      end
      e_bus = enc(c); e_ba = b; e_addr = a;
    end else begin
      e_bus = 4'b0111; e_ba = 2'd0; e_addr = 13'd0;
    end
    cyc++;
  endtask

  // hold a request until it is granted or refused; returns stall cycles
  task automatic do_req(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a,
                        output int stalls, output bit refused);
    bit g, s, e;
    stalls = 0; refused = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b1, c, b, a, g, s, e);
      if (s) stalls++;
      if (e) refused = 1;
      if (g || e) break;
    end
  endtask

  task automatic idle(input int n);
    bit g, s, e;
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 2'd0, 13'd0, g, s, e);
  endtask

  initial begin
    int st, exp_st;
    bit rf;
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; m_last[b] = -1000; end
    m_last_any = -1000;
    cyc = 0;
    c_rcd = cover_cycles(TRCD);
    c_rc  = cover_cycles(TRC);
    c_rrd = cover_cycles(TRRD);
    chk(c_rcd == 3 && c_rc == 9 && c_rrd == 2, "R1", "rounded limits",
        64'(c_rcd * 100 + c_rc * 10 + c_rrd), 64'd392);

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R11", "bus in reset",
        {60'd0, cs_n, ras_n, cas_n, we_n}, 64'h7);
    chk(open_mask == 4'd0, "R11", "banks closed in reset", {60'd0, open_mask}, 64'd0);
    rst_n = 1'b1;

    idle(3);

    // R11: first activate after reset goes straight through
    do_req(3'd1, 2'd0, 13'h0155, st, rf);
    chk(st == 0 && !rf, "R11", "first activate stalls", 64'(st), 64'd0);

    // R6 / R1: cross-bank activate right after
    do_req(3'd1, 2'd1, 13'h0AAA, st, rf);
    chk(st == c_rrd - 1, "R6 R1", "cross-bank stall cycles", 64'(st), 64'(c_rrd - 1));

    do_req(3'd2, 2'd0, 13'h0010, st, rf);
    do_req(3'd3, 2'd1, 13'h0020, st, rf);

    // R3 / R1: access right after activate on a fresh bank
    idle(2);
    do_req(3'd1, 2'd2, 13'h1234, st, rf);
    do_req(3'd2, 2'd2, 13'h0007, st, rf);
    chk(st == c_rcd - 1, "R3 R1", "access stall cycles", 64'(st), 64'(c_rcd - 1));

    // R2: write to closed bank 3
    do_req(3'd3, 2'd3, 13'h0044, st, rf);
    chk(rf, "R2", "closed-bank access refused", {63'd0, rf}, 64'd1);

    // R4: activate to open bank 0 with a new row
    do_req(3'd1, 2'd0, 13'h1FFF, st, rf);
    chk(rf, "R4", "open-bank activate refused", {63'd0, rf}, 64'd1);
    idle(1);

    // R7 then R5: precharge bank 2 and reopen at once
    do_req(3'd4, 2'd2, 13'h0000, st, rf);
    chk(st == 0 && !rf, "R7", "precharge immediate", 64'(st), 64'd0);
    exp_st = m_last[2] + c_rc - cyc;
    if (exp_st < 0) exp_st = 0;
    do_req(3'd1, 2'd2, 13'h0777, st, rf);
    chk(st == exp_st, "R5 R1", "same-bank stall cycles", 64'(st), 64'(exp_st));

    // R7 on a closed bank, R8 no-op request
    do_req(3'd4, 2'd3, 13'h0000, st, rf);
    do_req(3'd0, 2'd1, 13'h0003, st, rf);
    do_req(3'd6, 2'd2, 13'h0004, st, rf);

    // R5 across a precharge with waiting, max row
    do_req(3'd4, 2'd1, 13'h0000, st, rf);
    do_req(3'd1, 2'd3, 13'h1FFF, st, rf);
    do_req(3'd1, 2'd1, 13'h0001, st, rf);
    do_req(3'd3, 2'd3, 13'h1FFF, st, rf);
    do_req(3'd2, 2'd1, 13'h0002, st, rf);
    idle(4);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule